// File: doc/BRIEF.md
# B1 Section Parity Error Monitor

This block checks the section-level parity of a framed SONET/SDH byte stream that is still scrambled. One byte arrives per valid cycle. A start-of-frame marker flags the first byte of each frame, and a strobe flags the byte that carries the B1 parity. The block folds every bit of every frame into an even BIP-8 value. It then compares that value with the B1 byte carried in the frame that follows. Each comparison produces a mismatch count. That count goes out on a 4-bit per-frame port with a one-cycle valid pulse, for downstream error-rate logic. The same count is also added to a bit-error total and a block-error total.

A one-second tick copies both totals into host-readable snapshot registers. A configuration bit chooses whether the totals restart from zero or keep running after each copy. An error that lands in the same cycle as the copy is never lost. Any parity error sets a sticky status flag, which can raise an interrupt when enabled. The host clears the flag either by reading it or by writing to it, as configured. While a section, loss-of-signal or loss-of-frame defect is active, no comparison takes place.

Top module: `b1_parity_monitor`

## Requirements
- R1: The computed parity is the XOR of all valid bytes of a frame, including its B1 byte. The B1 byte of the next frame is compared against it. Two rising edges after the B1 byte is sampled, `frm_err_vld_o` is high for exactly one cycle and `frm_err_cnt_o` holds the number of differing bits. This happens for every compared frame, including frames with a count of 0.
- R2: On each comparison, the bit-error total grows by the mismatch count. The block-error total grows by 1 when that count is nonzero.
- R3: No comparison is made for the first frame after reset. No comparison is made for the first frame after a frame during which a defect was present.
- R4: A pulse on `sec_tick_i` copies both totals into snapshot registers: bit total at host address 1, block total at address 2. The copied values are the totals before that cycle's increment.
- R5: Config bit 0 (address 3) selects what happens on the tick. When it is 1, the totals restart from the increment of the tick cycle alone. When it is 0, the totals keep running.
- R6: Both totals saturate at all ones and never wrap.
- R7: Status bit 0 (address 0) is a sticky flag. It is set on any comparison with a nonzero count and stays set until the host clears it. A set in the same cycle as a clear wins.
- R8: Config bit 1 selects how the status flag clears. When it is 1, a read of address 0 returns the flag and then clears it. When it is 0, a read leaves the flag unchanged, and a write to address 0 with data bit 0 set clears it.
- R9: `irq_o` is high exactly when the status flag is set and config bit 2 (interrupt enable) is 1.
- R10: While `sef_i`, `los_i` or `lof_i` is high, no comparison is made, no count is reported and no total changes.
- R11: Read data is registered and valid in the cycle after a read strobe. Address 3 returns the three config bits. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 8 | Scrambled stream byte |
| data_vld_i | input | 1 | Byte valid |
| sof_i | input | 1 | First byte of a frame |
| b1_pos_i | input | 1 | Byte is the B1 parity byte |
| sef_i | input | 1 | Severely errored frame defect |
| los_i | input | 1 | Loss of signal defect |
| lof_i | input | 1 | Loss of frame defect |
| sec_tick_i | input | 1 | One-second snapshot pulse |
| hst_addr_i | input | 2 | Host register address |
| hst_wr_i | input | 1 | Host write strobe |
| hst_rd_i | input | 1 | Host read strobe |
| hst_wdata_i | input | CNT_W | Host write data |
| hst_rdata_o | output | CNT_W | Host read data |
| frm_err_cnt_o | output | 4 | Per-frame parity bit-error count |
| frm_err_vld_o | output | 1 | Per-frame count valid pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Several mismatch patterns are injected into the B1 byte: none, a single bit, a four-bit pattern, and all eight bits. Together they separate a correct population count from a block-only flag and from a stale parity value. Frames with each defect, and the frame that follows a defect, show that gating suppresses both the report and the totals. A tick placed in the same cycle as an increment separates the clear and retain policies and shows that no error is dropped. A long run of all-bit errors drives the totals into saturation.

// File: rtl/b1mon_pkg.sv
package b1mon_pkg;
  localparam int BIP_W = 8;
  localparam int INC_W = 4;
  localparam int CFG_W = 3;
  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_BITS   = 2'd1;
  localparam logic [1:0] A_BLKS   = 2'd2;
  localparam logic [1:0] A_CFG    = 2'd3;

  function automatic logic [INC_W-1:0] ones_in(input logic [BIP_W-1:0] v);
    logic [INC_W-1:0] n;
    n = '0;
    for (int i = 0; i < BIP_W; i++) n = n + INC_W'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/b1_frame_parity.sv
module b1_frame_parity import b1mon_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [BIP_W-1:0] data_i,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic             b1_i,
  input  logic             defect_i,
  output logic [BIP_W-1:0] mism_o,
  output logic             cmp_o
);
  logic [BIP_W-1:0] run_q, prev_q;
  logic             cur_ok_q, prev_ok_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q     <= '0;
      prev_q    <= '0;
      cur_ok_q  <= 1'b0;
      prev_ok_q <= 1'b0;
      mism_o    <= '0;
      cmp_o     <= 1'b0;
    end else begin
      cmp_o <= 1'b0;
      if (defect_i) begin
        cur_ok_q  <= 1'b0;
        prev_ok_q <= 1'b0;
      end
      if (vld_i) begin
        if (sof_i) begin
          prev_q    <= run_q;
          run_q     <= data_i;
          prev_ok_q <= cur_ok_q & ~defect_i;
          cur_ok_q  <= ~defect_i;
        end else begin
          run_q <= run_q ^ data_i;
        end
        if (b1_i && !sof_i && prev_ok_q && !defect_i) begin
          cmp_o  <= 1'b1;
          mism_o <= data_i ^ prev_q;
        end
      end
    end
  end
endmodule

// File: rtl/b1_err_tally.sv
module b1_err_tally import b1mon_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [BIP_W-1:0] mism_i,
  input  logic             cmp_i,
  output logic [INC_W-1:0] pop_o,
  output logic [INC_W-1:0] cnt_o,
  output logic             vld_o
);
  assign pop_o = cmp_i ? ones_in(mism_i) : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= cmp_i;
      if (cmp_i) cnt_o <= pop_o;
    end
  end
endmodule

// File: rtl/b1_sec_accum.sv
module b1_sec_accum #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] cache_o
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  assign base = (tick_i && clr_i) ? '0 : acc_o;
  assign sum  = {1'b0, base} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_o   <= '0;
      cache_o <= '0;
    end else begin
      acc_o <= sum[CNT_W] ? TOP : sum[CNT_W-1:0];
      if (tick_i) cache_o <= acc_o;
    end
  end
endmodule

// File: rtl/b1_parity_monitor.sv
module b1_parity_monitor import b1mon_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [7:0]       data_i,
  input  logic             data_vld_i,
  input  logic             sof_i,
  input  logic             b1_pos_i,
  input  logic             sef_i,
  input  logic             los_i,
  input  logic             lof_i,
  input  logic             sec_tick_i,
  input  logic [1:0]       hst_addr_i,
  input  logic             hst_wr_i,
  input  logic             hst_rd_i,
  input  logic [CNT_W-1:0] hst_wdata_i,
  output logic [CNT_W-1:0] hst_rdata_o,
  output logic [3:0]       frm_err_cnt_o,
  output logic             frm_err_vld_o,
  output logic             irq_o
);
  localparam int NACC = 2;

  logic             defect;
  logic [BIP_W-1:0] mism;
  logic             cmp;
  logic [INC_W-1:0] pop;
  logic [INC_W-1:0] inc_w   [NACC];
  logic [CNT_W-1:0] acc_w   [NACC];
  logic [CNT_W-1:0] cache_w [NACC];
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             sticky_q, sticky_d, set_ev, clr_req, clr_ev;
  logic             unused_wdata_hi;

  assign defect = sef_i | los_i | lof_i;

  b1_frame_parity u_par (
    .clk_i(clk_i), .rst_i(rst_i), .data_i(data_i), .vld_i(data_vld_i),
    .sof_i(sof_i), .b1_i(b1_pos_i), .defect_i(defect),
    .mism_o(mism), .cmp_o(cmp)
  );

  b1_err_tally u_tally (
    .clk_i(clk_i), .rst_i(rst_i), .mism_i(mism), .cmp_i(cmp),
    .pop_o(pop), .cnt_o(frm_err_cnt_o), .vld_o(frm_err_vld_o)
  );

  assign inc_w[0] = pop;
  assign inc_w[1] = INC_W'(pop != '0);

  for (genvar g = 0; g < NACC; g++) begin : gen_acc
    b1_sec_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
      .clk_i(clk_i), .rst_i(rst_i), .inc_i(inc_w[g]), .tick_i(sec_tick_i),
      .clr_i(cfg_q[0]), .acc_o(acc_w[g]), .cache_o(cache_w[g])
    );
  end

  assign unused_wdata_hi = ^hst_wdata_i[CNT_W-1:CFG_W];

  assign set_ev  = pop != '0;
  assign clr_req = (hst_rd_i || hst_wr_i) && hst_addr_i == A_STATUS;
  assign clr_ev  = cfg_q[1] ? (hst_rd_i && hst_addr_i == A_STATUS)
                            : (hst_wr_i && hst_addr_i == A_STATUS && hst_wdata_i[0]);
  assign sticky_d = set_ev | (sticky_q & ~clr_ev);
  assign cfg_d    = (hst_wr_i && hst_addr_i == A_CFG) ? hst_wdata_i[CFG_W-1:0] : cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q       <= '0;
      sticky_q    <= 1'b0;
      irq_o       <= 1'b0;
      hst_rdata_o <= '0;
    end else begin
      cfg_q    <= cfg_d;
      sticky_q <= sticky_d;
      irq_o    <= sticky_d & cfg_d[2];
      if (hst_rd_i) begin
        case (hst_addr_i)
          A_STATUS: hst_rdata_o <= CNT_W'(sticky_q);
          A_BITS:   hst_rdata_o <= cache_w[0];
          A_BLKS:   hst_rdata_o <= cache_w[1];
          default:  hst_rdata_o <= CNT_W'(cfg_q);
        endcase
      end
    end
  end
endmodule

// File: rtl/b1_parity_monitor_chk.sv
module b1_parity_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             defect_i,
  input logic             vld_i,
  input logic             sticky_i,
  input logic             clr_req_i,
  input logic             irq_i,
  input logic             tick_i,
  input logic             clr_mode_i,
  input logic [CNT_W-1:0] bit_acc_i,
  input logic [CNT_W-1:0] bit_cache_i
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_defect_gate_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    defect_i |-> ##2 !vld_i);

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> !vld_i);

  assert_sticky_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sticky_i) |-> $past(clr_req_i));

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i |-> sticky_i);

  assert_snapshot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> bit_cache_i == $past(bit_acc_i));

  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (bit_acc_i == TOP && !(tick_i && clr_mode_i)) |=> bit_acc_i == TOP);
endmodule

bind b1_parity_monitor b1_parity_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .defect_i(defect), .vld_i(frm_err_vld_o),
  .sticky_i(sticky_q), .clr_req_i(clr_req), .irq_i(irq_o), .tick_i(sec_tick_i),
  .clr_mode_i(cfg_q[0]), .bit_acc_i(acc_w[0]), .bit_cache_i(cache_w[0])
);

// File: tb/b1_parity_monitor_tb_top.sv
module b1_parity_monitor_tb_top;
  localparam int CW = 8;
  localparam int FL = 12;
  localparam int B1I = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic [7:0] data = 0;
  logic vld = 0, sof = 0, b1 = 0, sef = 0, los = 0, lof = 0, tick = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [CW-1:0] wdata = 0, rdata;
  logic [3:0] fcnt;
  logic fvld, irq;

  always #5 clk = ~clk;

  b1_parity_monitor #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_i(rst), .data_i(data), .data_vld_i(vld), .sof_i(sof),
    .b1_pos_i(b1), .sef_i(sef), .los_i(los), .lof_i(lof), .sec_tick_i(tick),
    .hst_addr_i(addr), .hst_wr_i(wr), .hst_rd_i(rd), .hst_wdata_i(wdata),
    .hst_rdata_o(rdata), .frm_err_cnt_o(fcnt), .frm_err_vld_o(fvld), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  int expq[$];
  logic [7:0] lcg = 8'h3c, prev_par = 0, cur_par = 0;
  bit prev_ok = 0;
  int acc_bit = 0, acc_blk = 0, c_bit = 0, c_blk = 0;
  bit clr_mode = 0;
  logic [CW-1:0] rv;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic idle();
    @(negedge clk);
    vld = 0; sof = 0; b1 = 0; sef = 0; los = 0; lof = 0; tick = 0;
  endtask

  // dsel: 0 none, 1 los, 2 sef, 3 lof (held whole frame)
  task automatic send_frame(input logic [7:0] flip, input int dsel, input bit tmid);
    int inc = 0;
    bit cmpx;
    cmpx = prev_ok && dsel == 0;
    cur_par = 0;
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      vld = 1; sof = (i == 0); b1 = (i == B1I);
      los = (dsel == 1); sef = (dsel == 2); lof = (dsel == 3);
      tick = tmid && (i == B1I + 1);
      lcg = lcg * 8'd29 + 8'd71;
      data = (i == B1I) ? (prev_par ^ flip) : lcg;
      cur_par ^= data;
      if (i == B1I && cmpx) begin
        inc = popc(flip);
        expq.push_back(inc);
      end
      if (i == B1I + 1) begin
        if (tmid) begin
          c_bit = acc_bit; c_blk = acc_blk;
          if (clr_mode) begin acc_bit = 0; acc_blk = 0; end
        end
        acc_bit = sat(acc_bit + inc);
        acc_blk = sat(acc_blk + (inc != 0 ? 1 : 0));
      end
    end
    prev_par = cur_par;
    prev_ok = (dsel == 0);
    idle();
  endtask

  task automatic tick_idle();
    @(negedge clk); tick = 1;
    c_bit = acc_bit; c_blk = acc_blk;
    if (clr_mode) begin acc_bit = 0; acc_blk = 0; end
    @(negedge clk); tick = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [CW-1:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic set_cfg(input logic [2:0] c);
    hwrite(2'd3, CW'(c));
    clr_mode = c[0];
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && fvld) begin
      if (expq.size() == 0) chk("R1/R3/R10 unexpected count pulse", int'(fcnt), -1);
      else chk("R1 per-frame count", int'(fcnt), expq.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset vld", int'(fvld), 0);
    chk("R11 reset irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      hread(2'(a), rv);
      chk("R11 reset register", int'(rv), 0);
    end

    // R1 R2 R3: first frame uncompared, then varied mismatch patterns
    set_cfg(3'b000);
    send_frame(8'h00, 0, 0);
    send_frame(8'h00, 0, 0);
    send_frame(8'h01, 0, 0);
    send_frame(8'h47, 0, 0);
    send_frame(8'hFF, 0, 0);
    tick_idle();
    hread(2'd1, rv); chk("R2 R4 bit total snapshot", int'(rv), c_bit);
    hread(2'd2, rv); chk("R2 R4 block total snapshot", int'(rv), c_blk);
    chk("R2 bit total value", c_bit, 13);
    chk("R9 irq masked", int'(irq), 0);
    hread(2'd0, rv); chk("R7 sticky set", int'(rv), 1);
    hread(2'd0, rv); chk("R8 read keeps flag", int'(rv), 1);
    hwrite(2'd0, 1);
    hread(2'd0, rv); chk("R8 write clears flag", int'(rv), 0);

    // R9 R8 clear on read
    set_cfg(3'b110);
    send_frame(8'h03, 0, 0);
    @(negedge clk);
    chk("R9 irq raised", int'(irq), 1);
    hread(2'd0, rv); chk("R8 read returns flag", int'(rv), 1);
    chk("R9 irq drops after clear", int'(irq), 0);
    hread(2'd0, rv); chk("R8 read cleared flag", int'(rv), 0);

    // R5 clear mode with error in the tick cycle
    set_cfg(3'b111);
    hread(2'd3, rv); chk("R11 config readback", int'(rv), 7);
    send_frame(8'h0F, 0, 1);
    hread(2'd1, rv); chk("R5 bit snapshot at tick", int'(rv), c_bit);
    tick_idle();
    hread(2'd1, rv); chk("R5 tick-cycle errors kept", int'(rv), 4);
    hread(2'd2, rv); chk("R5 block restarted", int'(rv), 1);
    chk("R5 model agrees", c_bit, 4);

    // R10 R3 defects
    set_cfg(3'b000);
    send_frame(8'hFF, 1, 0);
    send_frame(8'hFF, 0, 0);
    send_frame(8'hFF, 2, 0);
    send_frame(8'hFF, 0, 0);
    send_frame(8'hFF, 3, 0);
    send_frame(8'hFF, 0, 0);
    send_frame(8'h01, 0, 0);
    tick_idle();
    hread(2'd1, rv); chk("R10 R3 bit total after defects", int'(rv), c_bit);
    chk("R10 R3 model bit total", c_bit, 1);
    hread(2'd2, rv); chk("R10 block total after defects", int'(rv), c_blk);

    // R6 saturation in retain mode
    for (int k = 0; k < 40; k++) send_frame(8'hFF, 0, 0);
    tick_idle();
    hread(2'd1, rv); chk("R6 bit total saturates", int'(rv), MAXV);
    tick_idle();
    hread(2'd1, rv); chk("R6 retained after tick", int'(rv), MAXV);
    hread(2'd2, rv); chk("R6 block total", int'(rv), c_blk);

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule